// File: doc/BRIEF.md
# Grouped Interrupt Flag Controller

This block collects sixteen board interrupt lines, latches each one into a pending flag, and presents four CPU interrupt requests. Each request is the OR of a fixed, non-contiguous set of lines that are both pending and enabled. A sixteen-bit mask register enables or blocks each line. Software acknowledges a request by writing to the flag register. Writing a zero to a flag bit clears it, and writing a one leaves it as it is. To clear a set of bits, software therefore writes the complement of that set.

Lines 1 to 14 are active-low level sources. Line 15 is a push button that latches on a falling edge and drives a separate non-maskable request. Line 0 is unused. Every line passes through a synchroniser before it is captured. A pending flag remains set until software clears it, even after the source line has gone quiet. Masking a line hides its flag from its request output but leaves the flag in place.

A typical start-up sequence first writes 0x7FFE to the mask register and then writes 0x0000 to the flag register.

Top module: `irq_group_ctl`

## Requirements
- R1: After reset, the mask register reads 0xFFFF, the flag register reads 0x0000, and all four group requests and the non-maskable request are low.
- R2: The mask register is at bus address 0, with bit n belonging to line n. A write stores the full word, and a read on the same address returns the stored value. A mask bit of 1 blocks its line and a bit of 0 enables it.
- R3: The flag register is at bus address 1, with bit n belonging to line n. A write clears every flag bit written as 0 and leaves every bit written as 1 unchanged. A write never sets a flag.
- R4: For lines 1 to 14, the flag sets on every cycle in which the line's synchronised level is low. A line held low for at least one cycle shows its flag on the third rising edge after it falls. If a clear and an active level occur in the same cycle, the flag stays set.
- R5: Request 0 ORs lines 3 and 5. Request 1 ORs lines 4 and 6. Request 2 ORs lines 10, 11 and 12. Request 3 ORs lines 1, 2, 7, 8, 9, 13 and 14. A line counts toward its request only when its flag is 1 and its mask bit is 0. Requests are combinational from the registers.
- R6: Masking a pending line removes it from its request output on the cycle after the mask write, and its flag remains set.
- R7: Line 15 sets its flag only on a high-to-low transition of its synchronised level. Holding the line low does not set the flag again after it has been cleared. The non-maskable request equals flag 15, whatever the value of mask bit 15.
- R8: Flag bit 0 always reads 0. Line 0 and mask bit 0 have no effect on any request.
- R9: A flag stays set after its source returns inactive, until a flag write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in_n | input | 16 | Asynchronous board interrupt lines, active low |
| bus_addr | input | ADDR_W (2) | Register address: 0 for the mask register, 1 for the flag register |
| bus_wr_en | input | 1 | Write strobe, takes effect on the rising edge |
| bus_wr_data | input | 16 | Write data |
| bus_rd_data | output | 16 | Combinational read data for bus_addr |
| irq_req | output | 4 | Group interrupt requests to the CPU |
| nmi_req | output | 1 | Non-maskable request from line 15 |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a level line that is still active. The write must arrive while the synchronised level is still low, even though the software-visible flag is already set. The stimulus creates this case by holding a line low past the synchroniser delay and then writing zeros to the flag register. It then repeats the clear while the button line is held low, which shows the difference between the edge line and the level lines. A long pseudo-random phase then toggles the lines and issues writes at arbitrary phases against a per-clock reference model.

// File: rtl/irq_group_pkg.sv
// Shared constants, types and group membership for the grouped interrupt
// flag controller. Assumes 16 lines and 4 group outputs.
package irq_group_pkg;
    localparam int unsigned IRQ_LINES    = 16;
    localparam int unsigned CPU_LINES    = 4;
    localparam int unsigned BUTTON_LINE  = 15;
    localparam int unsigned SPARE_LINE   = 0;
    localparam int unsigned REG_MASK_OFS = 0;
    localparam int unsigned REG_FLAG_OFS = 1;

    typedef logic [IRQ_LINES-1:0] irq_vec_t;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_MASK,
        ACC_FLAG
    } acc_kind_e;

    // Lines that feed each group request.
    function automatic irq_vec_t group_members(input int unsigned grp);
        case (grp)
            0:       return 16'h0028;
            1:       return 16'h0050;
            2:       return 16'h1C00;
            3:       return 16'h6386;
            default: return '0;
        endcase
    endfunction

    // Lines that are level sensitive (all except the spare and the button).
    function automatic irq_vec_t level_lines();
        irq_vec_t v = '0;
        for (int i = 0; i < IRQ_LINES; i++) begin
            if (i != SPARE_LINE && i != BUTTON_LINE) v[i] = 1'b1;
        end
        return v;
    endfunction

    // Bits that can ever hold a flag.
    function automatic irq_vec_t live_lines();
        irq_vec_t v = '1;
        v[SPARE_LINE] = 1'b0;
        return v;
    endfunction

    localparam irq_vec_t LEVEL_LINES = level_lines();
    localparam irq_vec_t LIVE_LINES  = live_lines();
endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchroniser bank for asynchronous active-low lines.
// Assumes STAGES >= 2; resets every stage to the inactive (high) level.
module irq_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_n,
    output logic [WIDTH-1:0] sync_n
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '1;
        end else begin
            stage_q[0] <= async_n;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_n = stage_q[STAGES-1];
endmodule

// File: rtl/irq_capture.sv
// Turns synchronised lines into per-cycle set requests: level lines request
// while low, the button line requests on a falling edge only.
// Assumes the input is already synchronous to clk.
module irq_capture
    import irq_group_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t sync_n,
    output irq_vec_t set_vec
);
    logic button_prev_q;

    // Remember the previous synchronised button level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) button_prev_q <= 1'b1;
        else        button_prev_q <= sync_n[BUTTON_LINE];
    end

    // Build the set vector from level lines and the button edge.
    always_comb begin
        set_vec = ~sync_n & LEVEL_LINES;
        set_vec[BUTTON_LINE] = button_prev_q & ~sync_n[BUTTON_LINE];
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Pending flag register: clears through a write-zero word, sets from
// capture requests; a set in the same cycle as a clear wins.
// Assumes the spare bit is never stored.
module irq_flag_bank
    import irq_group_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t set_vec,
    input  logic     clr_en,
    input  irq_vec_t clr_word,
    output irq_vec_t flag_q
);
    irq_vec_t keep;
    irq_vec_t flag_d;

    // Compute the next flag word from keep mask and set requests.
    always_comb begin
        keep   = clr_en ? clr_word : '1;
        flag_d = ((flag_q & keep) | set_vec) & LIVE_LINES;
    end

    // Hold the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end
endmodule

// File: rtl/irq_group_or.sv
// Combines pending, enabled flags into fixed group requests and passes the
// button flag out as a non-maskable request.
// Assumes group membership comes from the package table.
module irq_group_or
    import irq_group_pkg::*;
(
    input  irq_vec_t             flag_q,
    input  irq_vec_t             mask_q,
    output logic [CPU_LINES-1:0] irq_req,
    output logic                 nmi_req
);
    irq_vec_t enabled;

    // Flags that are pending and not blocked.
    assign enabled = flag_q & ~mask_q & LIVE_LINES;

    for (genvar g = 0; g < CPU_LINES; g++) begin : g_group
        localparam irq_vec_t MEMBERS = group_members(g);
        // OR the enabled members of this group.
        assign irq_req[g] = |(enabled & MEMBERS);
    end

    assign nmi_req = flag_q[BUTTON_LINE];
endmodule

// File: rtl/irq_group_ctl.sv
// Top of the grouped interrupt flag controller: synchroniser, capture,
// flag bank, mask register, read mux and group OR.
// Assumes a single-cycle synchronous register bus with combinational read.
module irq_group_ctl
    import irq_group_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned ADDR_W      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          irq_in_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr_en,
    input  logic [15:0]          bus_wr_data,
    output logic [15:0]          bus_rd_data,
    output logic [3:0]           irq_req,
    output logic                 nmi_req
);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(REG_MASK_OFS);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(REG_FLAG_OFS);

    irq_vec_t  sync_n;
    irq_vec_t  set_vec;
    irq_vec_t  flag_q;
    irq_vec_t  mask_q;
    acc_kind_e acc;

    irq_sync #(.WIDTH(IRQ_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_n (irq_in_n),
        .sync_n  (sync_n)
    );

    irq_capture u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_n  (sync_n),
        .set_vec (set_vec)
    );

    // Decode which register the bus address selects.
    always_comb begin
        if (bus_addr == MASK_ADDR)      acc = ACC_MASK;
        else if (bus_addr == FLAG_ADDR) acc = ACC_FLAG;
        else                            acc = ACC_NONE;
    end

    irq_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_en   (bus_wr_en && acc == ACC_FLAG),
        .clr_word (bus_wr_data),
        .flag_q   (flag_q)
    );

    // Hold the mask register; everything blocked out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                            mask_q <= '1;
        else if (bus_wr_en && acc == ACC_MASK) mask_q <= bus_wr_data;
    end

    // Return the selected register on the read port.
    always_comb begin
        case (acc)
            ACC_MASK: bus_rd_data = mask_q;
            ACC_FLAG: bus_rd_data = flag_q;
            default:  bus_rd_data = '0;
        endcase
    end

    irq_group_or u_group (
        .flag_q  (flag_q),
        .mask_q  (mask_q),
        .irq_req (irq_req),
        .nmi_req (nmi_req)
    );
endmodule

// File: rtl/irq_group_ctl_checker.sv
// Property checker for the grouped interrupt flag controller, bound to the top.
module irq_group_ctl_checker
    import irq_group_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr_en,
    input logic [15:0]       bus_wr_data,
    input logic [15:0]       bus_rd_data,
    input logic [3:0]        irq_req,
    input logic              nmi_req,
    input irq_vec_t          flag_q,
    input irq_vec_t          mask_q,
    input irq_vec_t          set_vec
);
    localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(REG_MASK_OFS);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(REG_FLAG_OFS);

    assert_set_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

    assert_write_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == FLAG_ADDR && set_vec == '0)
        |=> ((flag_q & ~$past(flag_q)) == '0));

    assert_full_mask_silences_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == MASK_ADDR && bus_wr_data == 16'hFFFF)
        |=> (irq_req == 4'b0000));

    assert_spare_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == FLAG_ADDR) |-> (bus_rd_data[0] == 1'b0));

    assert_nmi_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !(bus_wr_en && bus_addr == FLAG_ADDR && !bus_wr_data[15]))
        |=> nmi_req);

    assert_nmi_from_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_req) |-> $past(set_vec[BUTTON_LINE]));

    for (genvar g = 0; g < CPU_LINES; g++) begin : g_grp_chk
        localparam irq_vec_t MEMBERS = group_members(g);
        assert_group_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ((flag_q & ~mask_q & MEMBERS) == '0) |-> !irq_req[g]);
    end
endmodule

bind irq_group_ctl irq_group_ctl_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_data (bus_wr_data),
    .bus_rd_data (bus_rd_data),
    .irq_req     (irq_req),
    .nmi_req     (nmi_req),
    .flag_q      (flag_q),
    .mask_q      (mask_q),
    .set_vec     (set_vec)
);

// File: tb/irq_group_ctl_bench.sv
module irq_group_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq_in_n = 16'hFFFF;
    logic [1:0]  bus_addr = 2'd0;
    logic        bus_wr_en = 1'b0;
    logic [15:0] bus_wr_data = 16'h0000;
    logic [15:0] bus_rd_data;
    logic [3:0]  irq_req;
    logic        nmi_req;

    int checks = 0;
    int fails  = 0;
    bit chk_on = 1'b0;

    always #4 clk = ~clk;

    irq_group_ctl u_irq_group_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in_n    (irq_in_n),
        .bus_addr    (bus_addr),
        .bus_wr_en   (bus_wr_en),
        .bus_wr_data (bus_wr_data),
        .bus_rd_data (bus_rd_data),
        .irq_req     (irq_req),
        .nmi_req     (nmi_req)
    );

    // Reference model: history of sampled lines plus flag and mask words.
    logic [15:0] hist [$];
    logic [15:0] m_flag = 16'h0000;
    logic [15:0] m_mask = 16'hFFFF;

    function automatic logic [15:0] grp(input int g);
        case (g)
            0: return 16'h0028;
            1: return 16'h0050;
            2: return 16'h1C00;
            default: return 16'h6386;
        endcase
    endfunction

    function automatic logic [3:0] exp_irq(input logic [15:0] f, input logic [15:0] m);
        logic [3:0] r = '0;
        for (int g = 0; g < 4; g++) r[g] = |(f & ~m & grp(g) & 16'hFFFE);
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            hist   = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
            m_flag = 16'h0000;
            m_mask = 16'hFFFF;
        end else begin
            logic [15:0] lvl, old, nf;
            hist.push_front(irq_in_n);
            lvl = hist[2];
            old = hist[3];
            nf = m_flag;
            if (bus_wr_en && bus_addr == 2'd1) nf = nf & bus_wr_data;
            for (int i = 1; i <= 14; i++) if (!lvl[i]) nf[i] = 1'b1;
            if (old[15] && !lvl[15]) nf[15] = 1'b1;
            nf[0] = 1'b0;
            if (bus_wr_en && bus_addr == 2'd0) m_mask = bus_wr_data;
            m_flag = nf;
            while (hist.size() > 4) void'(hist.pop_back());
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model.
    initial forever begin
        @(negedge clk);
        #2;
        if (chk_on) begin
            check("R5 group requests", {12'h0, irq_req}, {12'h0, exp_irq(m_flag, m_mask)});
            check("R7 nmi request", {15'h0, nmi_req}, {15'h0, m_flag[15]});
            if (bus_addr == 2'd0) check("R2 mask read", bus_rd_data, m_mask);
            else if (bus_addr == 2'd1) check("R3 flag read", bus_rd_data, m_flag);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr_data = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic read_expect(input string tag, input logic [1:0] a, input logic [15:0] exp);
        @(negedge clk);
        bus_addr = a;
        #2;
        check(tag, bus_rd_data, exp);
    endtask

    task automatic irq_expect(input string tag, input logic [3:0] exp_g, input logic exp_n);
        @(negedge clk);
        #2;
        check(tag, {11'h0, nmi_req, irq_req}, {11'h0, exp_n, exp_g});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        cycles(5);
        rst_n = 1'b1;
        chk_on = 1'b1;
        // R1 reset state
        read_expect("R1 mask after reset", 2'd0, 16'hFFFF);
        read_expect("R1 flags after reset", 2'd1, 16'h0000);
        irq_expect("R1 requests after reset", 4'b0000, 1'b0);

        // R2 typical setup
        bus_write(2'd0, 16'h7FFE);
        read_expect("R2 mask readback", 2'd0, 16'h7FFE);
        bus_write(2'd1, 16'h0000);

        // R4 capture of a masked line, R6 masked output quiet
        @(negedge clk); irq_in_n[3] = 1'b0;
        cycles(4);
        read_expect("R4 line 3 latched", 2'd1, 16'h0008);
        irq_expect("R6 masked line quiet", 4'b0000, 1'b0);
        bus_write(2'd0, 16'h7FF6);
        irq_expect("R5 line 3 drives request 0", 4'b0001, 1'b0);
        // R9 flag holds after release
        @(negedge clk); irq_in_n[3] = 1'b1;
        cycles(5);
        read_expect("R9 flag held after release", 2'd1, 16'h0008);
        // R6 masking keeps the flag
        bus_write(2'd0, 16'h7FFE);
        irq_expect("R6 remask hides request", 4'b0000, 1'b0);
        read_expect("R6 flag kept when masked", 2'd1, 16'h0008);
        // R3 write-zero clear
        bus_write(2'd1, 16'hFFF7);
        read_expect("R3 flag cleared", 2'd1, 16'h0000);

        // R4 set wins over a clear while level is active
        @(negedge clk); irq_in_n[10] = 1'b0;
        cycles(4);
        bus_write(2'd1, 16'h0000);
        read_expect("R4 set beats clear", 2'd1, 16'h0400);
        @(negedge clk); irq_in_n[10] = 1'b1;
        cycles(4);
        bus_write(2'd1, 16'h0000);
        read_expect("R3 cleared after release", 2'd1, 16'h0000);

        // R8 spare line has no effect
        bus_write(2'd0, 16'h0000);
        @(negedge clk); irq_in_n[0] = 1'b0;
        cycles(5);
        read_expect("R8 spare flag zero", 2'd1, 16'h0000);
        irq_expect("R8 spare no request", 4'b0000, 1'b0);
        @(negedge clk); irq_in_n[0] = 1'b1;

        // R5 walk every level line through its group
        for (int i = 1; i <= 14; i++) begin
            logic [3:0] eg;
            eg = '0;
            for (int g = 0; g < 4; g++) eg[g] = grp(g)[i];
            @(negedge clk); irq_in_n[i] = 1'b0;
            cycles(4);
            irq_expect("R5 group walk", eg, 1'b0);
            @(negedge clk); irq_in_n[i] = 1'b1;
            cycles(4);
            bus_write(2'd1, ~(16'h1 << i));
            irq_expect("R3 walk clear", 4'b0000, 1'b0);
        end

        // R7 button edge, mask bit 15 set
        bus_write(2'd0, 16'hFFFF);
        @(negedge clk); irq_in_n[15] = 1'b0;
        cycles(4);
        irq_expect("R7 edge sets nmi despite mask", 4'b0000, 1'b1);
        bus_write(2'd1, 16'h7FFF);
        cycles(3);
        read_expect("R7 held low no retrigger", 2'd1, 16'h0000);
        irq_expect("R7 nmi stays low", 4'b0000, 1'b0);
        @(negedge clk); irq_in_n[15] = 1'b1;
        cycles(4);
        irq_expect("R7 rising edge ignored", 4'b0000, 1'b0);
        @(negedge clk); irq_in_n[15] = 1'b0;
        cycles(4);
        irq_expect("R7 second edge", 4'b0000, 1'b1);
        @(negedge clk); irq_in_n[15] = 1'b1;
        cycles(4);
        bus_write(2'd1, 16'h0000);

        // Pseudo-random phase checked by the per-cycle model
        lfsr = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            irq_in_n = lfsr | {lfsr[7:0], lfsr[15:8]};
            bus_addr = {1'b0, lfsr[4]};
            bus_wr_en = (lfsr[3:0] == 4'h0) || (lfsr[3:0] == 4'h9);
            bus_wr_data = {lfsr[10:0], lfsr[15:11]};
        end
        @(negedge clk);
        bus_wr_en = 1'b0;
        irq_in_n = 16'hFFFF;
        cycles(5);
        finish_run();
    end
endmodule